// File: doc/BRIEF.md
# Multiplexed Bidirectional Latch Bus Exchanger

This block joins one data port, A, to two data ports, B1 and B2. All three ports are 12 bits wide. Four storage latches sit between them, two for each direction.

In the B-to-A direction, each B port loads its own latch. A select line chooses which of those two latches drives A. In the A-to-B direction, port A loads two separate latches. One of them drives only B1 and the other drives only B2.

Typical uses are address/data multiplexing, where two paths are merged onto one, and memory interleaving, where one path is split across two banks.

Bidirectional pads are modelled as three separate vectors per port: an input, an output and an output-enable. Each port has its own active-low enable control.

Each latch is a clocked register. A latch enable that is high at a rising clock edge loads the register. While the enable is high, the latch output is taken combinationally from its input, so the path looks transparent.

Top module: `mux_latch_exchanger`

## Requirements
- R1: While `le_a1_i` is high, `b1_o` equals `a_i` in the same cycle.
- R2: While `le_a1_i` is low, `b1_o` holds the value `a_i` had at the last rising edge at which `le_a1_i` was high, whatever `a_i` does now.
- R3: The B2-side forward latch behaves as in R1/R2 under `le_a2_i`, independently of `le_a1_i`.
- R4: The two return latches load `b1_i` under `le_b1_i` and `b2_i` under `le_b2_i`. Each is transparent while its enable is high and holds while it is low.
- R5: With `sel_i` = 1, `a_o` shows the B1 return latch. With `sel_i` = 0, `a_o` shows the B2 return latch.
- R6: While the selected return latch is closed, `a_o` keeps its held value and ignores the current B input.
- R7: The unselected return latch still tracks or captures its own B input. Switching `sel_i` later exposes the value it captured.
- R8: Each output-enable vector is all ones while its active-low control is 0, and all zeros while the control is 1. The data outputs keep showing the latch values either way.
- R9: `oe_b1_ni` and `oe_b2_ni` act independently, so neither, either or both B ports may drive.
- R10: While `rst_ni` is low, all four latches clear to zero. With every latch enable low, all data outputs then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Return-path select: 1 = B1 latch, 0 = B2 latch |
| le_b1_i | input | 1 | Enable of the B1 return latch |
| le_b2_i | input | 1 | Enable of the B2 return latch |
| le_a1_i | input | 1 | Enable of the A-to-B1 latch |
| le_a2_i | input | 1 | Enable of the A-to-B2 latch |
| oe_a_ni | input | 1 | Active-low output enable of port A |
| oe_b1_ni | input | 1 | Active-low output enable of port B1 |
| oe_b2_ni | input | 1 | Active-low output enable of port B2 |
| a_i | input | 12 | Port A pad input |
| a_o | output | 12 | Port A pad output |
| a_oe_o | output | 12 | Port A per-bit drive enable |
| b1_i | input | 12 | Port B1 pad input |
| b1_o | output | 12 | Port B1 pad output |
| b1_oe_o | output | 12 | Port B1 per-bit drive enable |
| b2_i | input | 12 | Port B2 pad input |
| b2_o | output | 12 | Port B2 pad output |
| b2_oe_o | output | 12 | Port B2 per-bit drive enable |

## Verification
The hold assertions assume that the controls and data seen at a clock edge are the values that existed for the whole preceding cycle. They also assume that the cycle just before a hold check was already out of reset. To meet this, the bench changes every input only at the falling edge.

The bench also sweeps all 256 combinations of select, latch-enable and output-enable settings with fresh data each cycle. This drives the latches through every open, close and reselect ordering without ever changing an input close to the rising edge.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
  localparam int unsigned MLX_DW = 12;
  typedef enum logic {
    SRC_B2 = 1'b0,
    SRC_B1 = 1'b1
  } mlx_src_e;
endpackage

// File: rtl/mlx_latch_cell.sv
module mlx_latch_cell #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (le_i) held_q <= d_i;
  end

  // open latch passes input straight through
  assign q_o = le_i ? d_i : held_q;
endmodule

// File: rtl/mlx_pad_enable.sv
module mlx_pad_enable #(
  parameter int unsigned W = 12
) (
  input  logic         oe_ni,
  output logic [W-1:0] oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign oe_o[i] = ~oe_ni;
  end
endmodule

// File: rtl/mlx_src_mux.sv
module mlx_src_mux #(
  parameter int unsigned W = 12
) (
  input  mlx_pkg::mlx_src_e sel_i,
  input  logic [W-1:0]      b1_view_i,
  input  logic [W-1:0]      b2_view_i,
  output logic [W-1:0]      y_o
);
  always_comb begin
    unique case (sel_i)
      mlx_pkg::SRC_B1: y_o = b1_view_i;
      default:         y_o = b2_view_i;
    endcase
  end
endmodule

// File: rtl/mux_latch_exchanger.sv
module mux_latch_exchanger #(
  parameter int unsigned W = mlx_pkg::MLX_DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         le_b1_i,
  input  logic         le_b2_i,
  input  logic         le_a1_i,
  input  logic         le_a2_i,
  input  logic         oe_a_ni,
  input  logic         oe_b1_ni,
  input  logic         oe_b2_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b1_i,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b1_oe_o,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] b2_o,
  output logic [W-1:0] b2_oe_o
);
  localparam int unsigned NBANK = 2;

  logic [NBANK-1:0]        fwd_le, ret_le, b_oe_n;
  logic [NBANK-1:0][W-1:0] fwd_q, ret_d, ret_q, b_oe;

  assign fwd_le = {le_a2_i, le_a1_i};
  assign ret_le = {le_b2_i, le_b1_i};
  assign ret_d  = {b2_i, b1_i};
  assign b_oe_n = {oe_b2_ni, oe_b1_ni};

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    mlx_latch_cell #(.W(W)) u_fwd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .le_i  (fwd_le[k]),
      .d_i   (a_i),
      .q_o   (fwd_q[k])
    );
    mlx_latch_cell #(.W(W)) u_ret (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .le_i  (ret_le[k]),
      .d_i   (ret_d[k]),
      .q_o   (ret_q[k])
    );
    mlx_pad_enable #(.W(W)) u_boe (
      .oe_ni(b_oe_n[k]),
      .oe_o (b_oe[k])
    );
  end

  mlx_src_mux #(.W(W)) u_mux (
    .sel_i    (mlx_pkg::mlx_src_e'(sel_i)),
    .b1_view_i(ret_q[0]),
    .b2_view_i(ret_q[1]),
    .y_o      (a_o)
  );

  mlx_pad_enable #(.W(W)) u_aoe (
    .oe_ni(oe_a_ni),
    .oe_o (a_oe_o)
  );

  assign b1_o    = fwd_q[0];
  assign b2_o    = fwd_q[1];
  assign b1_oe_o = b_oe[0];
  assign b2_oe_o = b_oe[1];
endmodule

// File: rtl/mlx_checker.sv
module mlx_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sel_i,
  input logic         le_b1_i,
  input logic         le_b2_i,
  input logic         le_a1_i,
  input logic         le_a2_i,
  input logic         oe_a_ni,
  input logic         oe_b1_ni,
  input logic         oe_b2_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b1_i,
  input logic [W-1:0] b1_o,
  input logic [W-1:0] b1_oe_o,
  input logic [W-1:0] b2_i,
  input logic [W-1:0] b2_o,
  input logic [W-1:0] b2_oe_o
);
  a_r1_b1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_a1_i |-> b1_o == a_i);
  a_r2_b1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !le_a1_i) |-> b1_o == $past(b1_o));
  a_r3_b2_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_a2_i |-> b2_o == a_i);
  a_r3_b2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !le_a2_i) |-> b2_o == $past(b2_o));
  a_r5_sel_b1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && le_b1_i) |-> a_o == b1_i);
  a_r5_sel_b2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && le_b2_i) |-> a_o == b2_i);
  a_r6_hold_b1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sel_i && $past(sel_i) && !le_b1_i) |-> a_o == $past(a_o));
  a_r6_hold_b2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !sel_i && !$past(sel_i) && !le_b2_i) |-> a_o == $past(a_o));
  a_r8_oe_a: assert property (@(posedge clk_i)
    a_oe_o == (oe_a_ni ? '0 : '1));
  a_r9_oe_b1: assert property (@(posedge clk_i)
    b1_oe_o == (oe_b1_ni ? '0 : '1));
  a_r9_oe_b2: assert property (@(posedge clk_i)
    b2_oe_o == (oe_b2_ni ? '0 : '1));
endmodule

bind mux_latch_exchanger mlx_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
  .le_b1_i(le_b1_i), .le_b2_i(le_b2_i), .le_a1_i(le_a1_i), .le_a2_i(le_a2_i),
  .oe_a_ni(oe_a_ni), .oe_b1_ni(oe_b1_ni), .oe_b2_ni(oe_b2_ni),
  .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
  .b1_i(b1_i), .b1_o(b1_o), .b1_oe_o(b1_oe_o),
  .b2_i(b2_i), .b2_o(b2_o), .b2_oe_o(b2_oe_o)
);

// File: tb/tb_mux_latch_exchanger.sv
module tb_mux_latch_exchanger;
  localparam int W = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_i = 1'b0, le_b1_i = 1'b0, le_b2_i = 1'b0, le_a1_i = 1'b0, le_a2_i = 1'b0;
  logic oe_a_ni = 1'b1, oe_b1_ni = 1'b1, oe_b2_ni = 1'b1;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic [W-1:0] a_o, a_oe_o, b1_o, b1_oe_o, b2_o, b2_oe_o;

  always #2.5 clk_i = ~clk_i;

  mux_latch_exchanger #(.W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
    .le_b1_i(le_b1_i), .le_b2_i(le_b2_i), .le_a1_i(le_a1_i), .le_a2_i(le_a2_i),
    .oe_a_ni(oe_a_ni), .oe_b1_ni(oe_b1_ni), .oe_b2_ni(oe_b2_ni),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b1_i(b1_i), .b1_o(b1_o), .b1_oe_o(b1_oe_o),
    .b2_i(b2_i), .b2_o(b2_o), .b2_oe_o(b2_oe_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_a1 = '0, m_a2 = '0, m_b1 = '0, m_b2 = '0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] view(input logic le, input logic [W-1:0] d, input logic [W-1:0] q);
    return le ? d : q;
  endfunction

  // sample between edges, then advance one clock and update reference
  task automatic check_and_step(input string a_tag);
    logic [W-1:0] eb1, eb2;
    #1;
    eb1 = view(le_b1_i, b1_i, m_b1);
    eb2 = view(le_b2_i, b2_i, m_b2);
    check(a_tag != "" ? a_tag : (sel_i ? (le_b1_i ? "R4" : "R6") : (le_b2_i ? "R4" : "R6")),
          a_o, sel_i ? eb1 : eb2);
    check(le_a1_i ? "R1" : "R2", b1_o, view(le_a1_i, a_i, m_a1));
    check("R3", b2_o, view(le_a2_i, a_i, m_a2));
    check("R8", a_oe_o, oe_a_ni ? '0 : '1);
    check("R9", b1_oe_o, oe_b1_ni ? '0 : '1);
    check("R9", b2_oe_o, oe_b2_ni ? '0 : '1);
    @(posedge clk_i);
    if (rst_ni) begin
      if (le_a1_i) m_a1 = a_i;
      if (le_a2_i) m_a2 = a_i;
      if (le_b1_i) m_b1 = b1_i;
      if (le_b2_i) m_b2 = b2_i;
    end
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    a_i = 12'hA5A; b1_i = 12'h3C3; b2_i = 12'h5F0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #1;
    // R10: reset clears all latches
    check("R10", a_o, '0);
    check("R10", b1_o, '0);
    check("R10", b2_o, '0);
    sel_i = 1'b1; #1;
    check("R10", a_o, '0);
    check("R8", a_oe_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: both return latches open, select toggles the source
    le_b1_i = 1; le_b2_i = 1; b1_i = 12'h111; b2_i = 12'h222; sel_i = 1;
    check_and_step("R5");
    sel_i = 0;
    check_and_step("R5");

    // R7: capture B1 while B2 is routed, then expose it
    sel_i = 0; le_b1_i = 1; le_b2_i = 0; b1_i = 12'h7E1;
    check_and_step("");
    le_b1_i = 0; b1_i = 12'h018;
    check_and_step("");
    sel_i = 1;
    check_and_step("R7");
    b1_i = 12'hFFF;
    check_and_step("R7");

    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 256; c++) begin
        logic [7:0] cv;
        cv = 8'(c) ^ 8'(rep * 8'h5B);
        {sel_i, le_b1_i, le_b2_i, le_a1_i, le_a2_i, oe_a_ni, oe_b1_ni, oe_b2_ni} = cv;
        a_i  = W'($urandom);
        b1_i = W'($urandom);
        b2_i = W'($urandom);
        check_and_step("");
      end
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end
endmodule